// File: doc/BRIEF.md
# Ripple Magnitude Comparator (low bit first)

This block compares two unsigned operands of equal width and reports, through three mutually exclusive flags, whether the first operand is equal to, greater than or less than the second. It is purely combinational. The flags are produced by a chain of identical one-bit cells. The chain starts at bit 0 and ends at the most significant bit.

Each cell receives a one-hot status from the cell beneath it, in the form equal, greater or less. It also receives the operand bits at its own position. If those two bits match, the cell hands the status upward untouched. If they differ, the cell replaces the status with greater or less, according to which operand holds the 1. The last cell to see a difference is therefore the highest differing bit, and its verdict is what leaves the top of the chain. Below bit 0 the chain is seeded with "equal". The width is a parameter of at least 1.

Top module: `ripple_mag_cmp`

## Requirements
- R1: When `a_i` equals `b_i`, the outputs are `eq_o`=1, `gt_o`=0, `lt_o`=0.
- R2: When `a_i` is greater than `b_i` as an unsigned number, the outputs are `gt_o`=1, `eq_o`=0, `lt_o`=0.
- R3: When `a_i` is less than `b_i` as an unsigned number, the outputs are `lt_o`=1, `eq_o`=0, `gt_o`=0.
- R4: Exactly one of `eq_o`, `gt_o` and `lt_o` is 1 for every pair of inputs, and this holds at every stage of the chain.
- R5: A bit position at which both operands hold the same value passes the status from below unchanged. When the upper bits of the operands match, the lowest bits alone decide the result.
- R6: At a bit position where the operands differ, the status from below is overridden. A 1 in `a_i` at that position gives greater, and a 1 in `b_i` gives less. The highest differing bit therefore decides the result, whatever the lower bits hold.
- R7: The operands are unsigned. An operand whose top bit is set compares greater than any operand whose top bit is clear and whose higher bits are otherwise equal. All ones compares greater than zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| eq_o | output | 1 | Set when the operands are equal |
| gt_o | output | 1 | Set when `a_i` is greater than `b_i` |
| lt_o | output | 1 | Set when `a_i` is less than `b_i` |

## Verification
Equal operands, including zero and all ones, show that the seeded "equal" reaches the top when no cell overrides it. Pairs that differ only in bit 0 show that matching upper cells pass the verdict through. Pairs whose top bits disagree while their lower bits point the opposite way show that the higher cell wins over the lower ones. A 4-bit instance is tried with every operand pair, and a 16-bit instance with random pairs. Both are compared against the integer ordering, so any wrong verdict from a single cell equation shows up.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // One-hot comparison status carried between cells.
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmp_status_t;

  // Status entering the chain below bit 0: nothing compared yet, so equal.
  localparam cmp_status_t CMP_SEED = '{eq: 1'b1, gt: 1'b0, lt: 1'b0};

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
  import cmp_pkg::*;
(
  input  logic        a_bit,
  input  logic        b_bit,
  input  cmp_status_t st_in,
  output cmp_status_t st_out
);

  always_comb begin
    st_out.gt = (a_bit & ~b_bit) | (a_bit & st_in.gt) | (~b_bit & st_in.gt);
    st_out.eq = (~a_bit & ~b_bit & st_in.eq) | (a_bit & b_bit & st_in.eq);
    st_out.lt = (~a_bit & b_bit) | (~a_bit & st_in.lt) | (b_bit & st_in.lt);
  end

  // R4: a one-hot status in gives a one-hot status out
  always_comb begin
    if ($onehot(st_in)) begin
      a_r4_cell_onehot: assert ($onehot(st_out))
        else $error("R4: cell status not one-hot");
    end
  end

  // R5: matching bits leave the status alone
  always_comb begin
    if (a_bit == b_bit) begin
      a_r5_pass_through: assert (st_out == st_in)
        else $error("R5: status altered on matching bits");
    end
  end

  // R6: differing bits override whatever came from below
  always_comb begin
    if (a_bit && !b_bit) begin
      a_r6_override_gt: assert (st_out.gt && !st_out.eq && !st_out.lt)
        else $error("R6: greater not forced");
    end
    if (!a_bit && b_bit) begin
      a_r6_override_lt: assert (st_out.lt && !st_out.eq && !st_out.gt)
        else $error("R6: less not forced");
    end
  end

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  output cmp_status_t      st_top
);

  localparam int NODES = WIDTH + 1;

  // Node k is the status below bit k; node WIDTH is the result.
  cmp_status_t [NODES-1:0] node;

  assign node[0] = CMP_SEED;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    cmp_bit_cell u_cell (
      .a_bit  (a_vec[k]),
      .b_bit  (b_vec[k]),
      .st_in  (node[k]),
      .st_out (node[k+1])
    );
  end

  assign st_top = node[NODES-1];

endmodule

// File: rtl/ripple_mag_cmp.sv
module ripple_mag_cmp
  import cmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o,
  output logic             gt_o,
  output logic             lt_o
);

  cmp_status_t result;

  cmp_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec  (a_i),
    .b_vec  (b_i),
    .st_top (result)
  );

  assign eq_o = result.eq;
  assign gt_o = result.gt;
  assign lt_o = result.lt;

  // Flags checked against the plain integer ordering of the operands.
  always_comb begin
    a_r4_flags_onehot: assert ($onehot({eq_o, gt_o, lt_o}))
      else $error("R4: output flags not one-hot");
    a_r1_equal: assert (eq_o == (a_i == b_i))
      else $error("R1: equal flag wrong");
    a_r2_greater: assert (gt_o == (a_i > b_i))
      else $error("R2: greater flag wrong");
    a_r3_less: assert (lt_o == (a_i < b_i))
      else $error("R3: less flag wrong");
  end

endmodule

// File: tb/sim_ripple_mag_cmp.sv
`timescale 1ns/1ps
module sim_ripple_mag_cmp;

  localparam int WW = 16;
  localparam int NW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [WW-1:0] a, b;
  logic          eq, gt, lt;
  logic [NW-1:0] na, nb;
  logic          neq, ngt, nlt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ripple_mag_cmp #(.WIDTH(WW)) u0 (
    .a_i(a), .b_i(b), .eq_o(eq), .gt_o(gt), .lt_o(lt));

  ripple_mag_cmp #(.WIDTH(NW)) u1 (
    .a_i(na), .b_i(nb), .eq_o(neq), .gt_o(ngt), .lt_o(nlt));

  // Flags as {eq, gt, lt}
  function automatic logic [2:0] ref_flags(longint unsigned x, longint unsigned y);
    return {x == y, x > y, x < y};
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp,
                     longint unsigned x, longint unsigned y);
    checks++;
    if (act !== exp || $countones(act) != 1) begin
      fails++;
      $display("FAIL %s a=%0h b=%0h actual=%b expected=%b", req, x, y, act, exp);
    end
  endtask

  task automatic apply_wide(string req, logic [WW-1:0] x, logic [WW-1:0] y);
    @(negedge clk);
    a = x; b = y;
    #1;
    chk(req, {eq, gt, lt}, ref_flags(x, y), x, y);
  endtask

  task automatic t_idle;
    // Reset-like idle state: both operands zero gives equal (R1)
    apply_wide("R1", '0, '0);
  endtask

  task automatic t_equal;
    apply_wide("R1", '1, '1);
    apply_wide("R1", 16'hA5C3, 16'hA5C3);
    apply_wide("R1", 16'h0001, 16'h0001);
  endtask

  task automatic t_low_bit;
    // Upper bits match, bit 0 decides (R5)
    apply_wide("R5", 16'h8001, 16'h8000);
    apply_wide("R5", 16'h7FFE, 16'h7FFF);
  endtask

  task automatic t_override;
    // Higher difference beats opposite lower bits (R6)
    apply_wide("R6", 16'h0100, 16'h00FF);
    apply_wide("R6", 16'h10FF, 16'h1100);
    apply_wide("R6", 16'h4000, 16'h3FFF);
  endtask

  task automatic t_unsigned;
    apply_wide("R7", '1, '0);
    apply_wide("R7", 16'h8000, 16'h7FFF);
    apply_wide("R7", 16'h0000, 16'hFFFF);
  endtask

  task automatic t_exhaustive_narrow;
    for (int x = 0; x < (1 << NW); x++) begin
      for (int y = 0; y < (1 << NW); y++) begin
        @(negedge clk);
        na = NW'(x); nb = NW'(y);
        #1;
        chk(x == y ? "R1" : (x > y ? "R2" : "R3"),
            {neq, ngt, nlt}, ref_flags(x, y), x, y);
        chk("R4", {2'b00, $countones({neq, ngt, nlt}) == 1}, 3'b001, x, y);
      end
    end
  endtask

  task automatic t_random_wide;
    for (int i = 0; i < 2000; i++) begin
      logic [WW-1:0] x, y;
      x = WW'($urandom);
      y = (i % 4 == 0) ? x : WW'($urandom);
      apply_wide((x > y) ? "R2" : ((x < y) ? "R3" : "R1"), x, y);
    end
  endtask

  initial begin
    a = '0; b = '0; na = '0; nb = '0;
    t_idle();
    t_equal();
    t_low_bit();
    t_override();
    t_unsigned();
    t_exhaustive_narrow();
    t_random_wide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule